// File: doc/BRIEF.md
# SPI-mode SD block write receiver

This block sits on the card side of an SPI link and takes in data blocks that a host sends during single or multiple block write operations. Every byte the host clocks in reaches the block as one exchange, and the block answers each exchange with exactly one reply byte. While idle it looks for a start token. Once it sees one, it passes the payload bytes one at a time to a card-side write port. It then swallows the two trailing CRC bytes without checking them and answers with an "accepted" data-response token.

A multiple block write ends with a stop token. On that token the block sends a one-cycle stop-transmission request (command 12) to the card. It then replies with zero bytes for as long as the card reports busy, and with 0xFF once the card is free.

A block is closed after `BLOCK_LEN` payload bytes. The default is 512. The block also closes early if the card drops its receive-ready flag.

Top module: `sdw_block_writer`

## Requirements
- R1: Reset state (synchronous, active-high `rst`): `rsp_valid`, `wr_valid` and `stop_req` are low, and `rsp_byte` reads 0xFF.
- R2: Each cycle with `xfer_valid` high causes exactly one `rsp_valid` pulse in the following cycle. `rsp_byte` carries the reply for that exchange, and `rsp_valid` never rises without an exchange.
- R3: In idle, the byte 0xFE (single block) or 0xFC (multi-block write) starts a data block. The reply to the token itself is 0xFF.
- R4: During a block, each exchanged byte appears on `wr_byte` with a one-cycle `wr_valid` pulse in the cycle after the exchange, in arrival order. The reply to each data byte is 0xFF. Token values inside the payload count as data.
- R5: After `BLOCK_LEN` data bytes, the next two exchanges are CRC bytes. They are not forwarded and each gets the reply 0xFF.
- R6: If `card_rx_ready` is low during the exchange of a data byte, that byte is still forwarded and it is the last byte of the block. The two CRC bytes follow.
- R7: The exchange after the second CRC byte gets the reply 0x05. The block is idle again after it.
- R8: The payload byte count restarts at every start token, so a block that follows a short block is again `BLOCK_LEN` bytes long.
- R9: In idle, the byte 0xFD gives a single-cycle `stop_req` pulse in the cycle after the exchange. The reply to the token is 0xFF.
- R10: After a stop token, each exchange gets the reply 0x00 while `card_busy` is high during it. The first exchange with `card_busy` low gets 0xFF and returns the block to idle.
- R11: In idle, any byte other than 0xFE, 0xFC and 0xFD gets the reply 0xFF. It causes no write and no stop request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_valid | input | 1 | One SPI byte exchange happens this cycle |
| xfer_byte | input | 8 | Byte received from the host in this exchange |
| rsp_valid | output | 1 | Reply for the previous cycle's exchange is present |
| rsp_byte | output | 8 | Reply byte returned to the host |
| wr_valid | output | 1 | Payload byte pushed to the card |
| wr_byte | output | 8 | Payload byte value |
| card_rx_ready | input | 1 | Card can take more payload in this block |
| stop_req | output | 1 | Stop-transmission request pulse to the card |
| card_busy | input | 1 | Card still finishing after a stop request |

## Verification
The main path is driven in four ways:
- A full single-block transfer, whose payload includes the token values 0xFE, 0xFC and 0xFD, so token decoding that leaks into the data phase shows up as a missing write.
- A multi-block transfer that the card cuts short. This separates the early-close path from the length-limit path.
- A full-length block right after the short one. This exposes a byte count that is not restarted.
- Junk bytes in idle, before and after blocks. These show whether the block really returned to idle or wrongly raised writes or stop requests.

The stop sequence runs with several busy exchanges before the card frees, which checks both reply values and the return to idle.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    localparam logic [7:0] TOK_SINGLE = 8'hFE;
    localparam logic [7:0] TOK_MULTI  = 8'hFC;
    localparam logic [7:0] TOK_STOP   = 8'hFD;
    localparam logic [7:0] RSP_ACCEPT = 8'h05;
    localparam logic [7:0] RSP_FILL   = 8'hFF;
    localparam logic [7:0] RSP_BUSY   = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_CRC,
        ST_ACK,
        ST_STOP_WAIT
    } wr_state_e;

    typedef enum logic [1:0] {
        TK_NONE,
        TK_START,
        TK_STOP
    } tok_class_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } byte_beat_t;

    function automatic tok_class_e classify_token(input logic [7:0] b);
        tok_class_e c;
        if (b == TOK_SINGLE || b == TOK_MULTI) begin
            c = TK_START;
        end else if (b == TOK_STOP) begin
            c = TK_STOP;
        end else begin
            c = TK_NONE;
        end
        return c;
    endfunction

endpackage

// File: rtl/sdw_token_decode.sv
module sdw_token_decode
    import sdw_pkg::*;
(
    input  logic [7:0] in_byte,
    output tok_class_e tok
);

    always_comb begin
        tok = classify_token(in_byte);
    end

endmodule

// File: rtl/sdw_byte_counter.sv
module sdw_byte_counter #(
    parameter int BLK_LEN = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int CW = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(BLK_LEN - 1);

    logic [CW-1:0] cnt_q;

    assign last = (cnt_q == LAST_VAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            if (last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(cnt_q) < BLK_LEN) else $error("byte count out of range"); // R5

    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0)) else $error("count not cleared"); // R8

endmodule

// File: rtl/sdw_ctrl.sv
module sdw_ctrl
    import sdw_pkg::*;
#(
    parameter int CRC_BYTES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       xfer_valid,
    input  logic [7:0] xfer_byte,
    input  logic       card_rx_ready,
    input  logic       card_busy,
    input  tok_class_e tok,
    input  logic       blk_last,
    output logic       cnt_clr,
    output logic       cnt_inc,
    output logic       rsp_valid,
    output logic [7:0] rsp_byte,
    output logic       wr_valid,
    output logic [7:0] wr_byte,
    output logic       stop_req
);

    localparam int CRCW = (CRC_BYTES > 1) ? $clog2(CRC_BYTES) : 1;
    localparam logic [CRCW-1:0] CRC_LAST = CRCW'(CRC_BYTES - 1);

    wr_state_e       state_q, state_n;
    logic [CRCW-1:0] crc_q, crc_n;
    logic [7:0]      reply;
    byte_beat_t      wr_n;
    logic            stop_n;

    always_comb begin
        state_n = state_q;
        crc_n   = crc_q;
        reply   = RSP_FILL;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        wr_n    = '{valid: 1'b0, data: xfer_byte};
        stop_n  = 1'b0;
        if (xfer_valid) begin
            case (state_q)
                ST_IDLE: begin
                    if (tok == TK_START) begin
                        cnt_clr = 1'b1;
                        state_n = ST_DATA;
                    end else if (tok == TK_STOP) begin
                        stop_n  = 1'b1;
                        state_n = ST_STOP_WAIT;
                    end
                end
                ST_DATA: begin
                    wr_n.valid = 1'b1;
                    cnt_inc    = 1'b1;
                    if (blk_last || !card_rx_ready) begin
                        crc_n   = '0;
                        state_n = ST_CRC;
                    end
                end
                ST_CRC: begin
                    if (crc_q == CRC_LAST) begin
                        state_n = ST_ACK;
                    end else begin
                        crc_n = crc_q + CRCW'(1);
                    end
                end
                ST_ACK: begin
                    reply   = RSP_ACCEPT;
                    state_n = ST_IDLE;
                end
                ST_STOP_WAIT: begin
                    if (card_busy) begin
                        reply = RSP_BUSY;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
                default: begin
                    state_n = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            crc_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_byte  <= RSP_FILL;
            wr_valid  <= 1'b0;
            wr_byte   <= '0;
            stop_req  <= 1'b0;
        end else begin
            state_q   <= state_n;
            crc_q     <= crc_n;
            rsp_valid <= xfer_valid;
            if (xfer_valid) begin
                rsp_byte <= reply;
            end
            wr_valid <= wr_n.valid;
            if (wr_n.valid) begin
                wr_byte <= wr_n.data;
            end
            stop_req <= stop_n;
        end
    end

    AST_REPLY_HAS_XFER: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(xfer_valid)) else $error("reply without exchange"); // R2

    AST_XFER_GETS_REPLY: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |=> rsp_valid) else $error("exchange without reply"); // R2

    AST_WRITE_FILL_REPLY: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (rsp_valid && rsp_byte == RSP_FILL)) else $error("write with non-fill reply"); // R4

    AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> !stop_req) else $error("stop request too long"); // R9

    AST_STOP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> !wr_valid) else $error("stop during write"); // R9

    AST_ACCEPT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_byte == RSP_ACCEPT) |-> !wr_valid) else $error("accept with write"); // R7

endmodule

// File: rtl/sdw_block_writer.sv
module sdw_block_writer
    import sdw_pkg::*;
#(
    parameter int BLOCK_LEN = 512,
    parameter int CRC_BYTES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       xfer_valid,
    input  logic [7:0] xfer_byte,
    output logic       rsp_valid,
    output logic [7:0] rsp_byte,
    output logic       wr_valid,
    output logic [7:0] wr_byte,
    input  logic       card_rx_ready,
    output logic       stop_req,
    input  logic       card_busy
);

    tok_class_e tok;
    logic       cnt_clr;
    logic       cnt_inc;
    logic       blk_last;

    sdw_token_decode u_dec (
        .in_byte (xfer_byte),
        .tok     (tok)
    );

    sdw_byte_counter #(
        .BLK_LEN (BLOCK_LEN)
    ) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .last (blk_last)
    );

    sdw_ctrl #(
        .CRC_BYTES (CRC_BYTES)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .xfer_valid    (xfer_valid),
        .xfer_byte     (xfer_byte),
        .card_rx_ready (card_rx_ready),
        .card_busy     (card_busy),
        .tok           (tok),
        .blk_last      (blk_last),
        .cnt_clr       (cnt_clr),
        .cnt_inc       (cnt_inc),
        .rsp_valid     (rsp_valid),
        .rsp_byte      (rsp_byte),
        .wr_valid      (wr_valid),
        .wr_byte       (wr_byte),
        .stop_req      (stop_req)
    );

    AST_STOP_FROM_TOKEN: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> ($past(xfer_valid) && $past(xfer_byte) == TOK_STOP)) else $error("stop without token"); // R9

    AST_WRITE_MATCHES_IN: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_byte == $past(xfer_byte))) else $error("write byte mismatch"); // R4

endmodule

// File: tb/sdw_block_writer_tb_top.sv
module sdw_block_writer_tb_top;

    localparam int BLK = 512;

    typedef struct {
        logic [7:0] b;
        string      tag;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       xfer_valid = 1'b0;
    logic [7:0] xfer_byte = 8'hFF;
    logic       card_rx_ready = 1'b1;
    logic       card_busy = 1'b0;
    logic       rsp_valid;
    logic [7:0] rsp_byte;
    logic       wr_valid;
    logic [7:0] wr_byte;
    logic       stop_req;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    string cur_tag = "R11";

    exp_item_t rsp_q[$];
    exp_item_t wr_q[$];
    exp_item_t stop_q[$];

    always #5 clk = ~clk;

    sdw_block_writer #(.BLOCK_LEN(BLK)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .xfer_valid    (xfer_valid),
        .xfer_byte     (xfer_byte),
        .rsp_valid     (rsp_valid),
        .rsp_byte      (rsp_byte),
        .wr_valid      (wr_valid),
        .wr_byte       (wr_byte),
        .card_rx_ready (card_rx_ready),
        .stop_req      (stop_req),
        .card_busy     (card_busy)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Driver: one exchange, pushes expected reply / write / stop
    task automatic exchange(input logic [7:0] b, input logic busy, input logic rdy,
                            input logic [7:0] exp_rsp, input string tag,
                            input bit exp_wr, input bit exp_stop);
        exp_item_t it;
        @(negedge clk);
        xfer_valid    = 1'b1;
        xfer_byte     = b;
        card_busy     = busy;
        card_rx_ready = rdy;
        cur_tag       = tag;
        it.b = exp_rsp; it.tag = tag; rsp_q.push_back(it);
        if (exp_wr) begin
            it.b = b; wr_q.push_back(it);
        end
        if (exp_stop) begin
            it.b = 8'h01; stop_q.push_back(it);
        end
        @(negedge clk);
        xfer_valid    = 1'b0;
        card_rx_ready = 1'b1;
    endtask

    // Monitor
    always @(negedge clk) begin
        if (!rst && !finished) begin
            exp_item_t it;
            if (rsp_valid) begin
                if (rsp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected reply", rsp_byte, 0);
                end else begin
                    it = rsp_q.pop_front();
                    check(rsp_byte == it.b, it.tag, "reply", rsp_byte, it.b);
                end
            end
            if (wr_valid) begin
                if (wr_q.size() == 0) begin
                    check(1'b0, cur_tag, "unexpected write", wr_byte, 0);
                end else begin
                    it = wr_q.pop_front();
                    check(wr_byte == it.b, it.tag, "write byte", wr_byte, it.b);
                end
            end
            if (stop_req) begin
                if (stop_q.size() == 0) begin
                    check(1'b0, cur_tag, "unexpected stop request", 1, 0);
                end else begin
                    it = stop_q.pop_front();
                    check(1'b1, it.tag, "stop request", 1, 1);
                end
            end
        end
    end

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 13 + seed) & 8'hFF);
    endfunction

    task automatic send_block(input logic [7:0] tok, input int n, input int drop_at,
                              input int seed, input string tag);
        exchange(tok, 1'b0, 1'b1, 8'hFF, "R3", 1'b0, 1'b0);
        for (int i = 0; i < n; i++) begin
            exchange(pat(i, seed), 1'b0, (i != drop_at), 8'hFF, tag, 1'b1, 1'b0);
        end
        exchange(8'hA5, 1'b0, 1'b1, 8'hFF, "R5", 1'b0, 1'b0);
        exchange(8'h5A, 1'b0, 1'b1, 8'hFF, "R5", 1'b0, 1'b0);
        exchange(8'hFF, 1'b0, 1'b1, 8'h05, "R7", 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
        check(wr_valid == 1'b0, "R1", "wr_valid after reset", wr_valid, 0);
        check(stop_req == 1'b0, "R1", "stop_req after reset", stop_req, 0);
        check(rsp_byte == 8'hFF, "R1", "rsp_byte after reset", rsp_byte, 8'hFF);

        // R11: junk bytes in idle
        exchange(8'h00, 1'b0, 1'b1, 8'hFF, "R11", 1'b0, 1'b0);
        exchange(8'h42, 1'b0, 1'b1, 8'hFF, "R11", 1'b0, 1'b0);
        exchange(8'h05, 1'b0, 1'b1, 8'hFF, "R11", 1'b0, 1'b0);

        // R3/R4/R5/R7: full single block (payload contains FE/FC/FD values)
        send_block(8'hFE, BLK, -1, 1, "R4");
        exchange(8'h40, 1'b0, 1'b1, 8'hFF, "R11", 1'b0, 1'b0);

        // R6: multi block cut short by the card after 10 bytes
        send_block(8'hFC, 10, 9, 77, "R6");

        // R8: next block full length again
        send_block(8'hFC, BLK, -1, 200, "R8");

        // R9/R10: stop token with busy card
        exchange(8'hFD, 1'b0, 1'b1, 8'hFF, "R9", 1'b0, 1'b1);
        exchange(8'hFF, 1'b1, 1'b1, 8'h00, "R10", 1'b0, 1'b0);
        exchange(8'hFF, 1'b1, 1'b1, 8'h00, "R10", 1'b0, 1'b0);
        exchange(8'hFE, 1'b1, 1'b1, 8'h00, "R10", 1'b0, 1'b0);
        exchange(8'hFF, 1'b0, 1'b1, 8'hFF, "R10", 1'b0, 1'b0);
        // back in idle: busy level no longer matters
        exchange(8'h40, 1'b1, 1'b1, 8'hFF, "R10", 1'b0, 1'b0);
        exchange(8'h12, 1'b0, 1'b1, 8'hFF, "R11", 1'b0, 1'b0);

        repeat (4) @(negedge clk);
        check(rsp_q.size() == 0, "R2", "replies outstanding", rsp_q.size(), 0);
        check(wr_q.size() == 0, "R4", "writes outstanding", wr_q.size(), 0);
        check(stop_q.size() == 0, "R9", "stops outstanding", stop_q.size(), 0);
        finish_run();
    end

endmodule